// File: doc/BRIEF.md
# Processor Status, Control Flags and Interrupt Latch

This block keeps the small set of single-bit state that a microcoded processor consults on every instruction. It holds two control flags, paging enable and the user/supervisor mode, and two ALU status bits, result-was-zero and carry/overflow. It also catches events on eight interrupt request lines. Three separate one-cycle microcode strobes update it. One loads the control flags from the internal Z bus. One captures the ALU's zero and carry outputs. One clears interrupt flags using a write-one-to-clear mask taken from the low byte of the Z bus.

All state is read back as one 16-bit word for the datapath. Paging enable and mode are also presented as dedicated pins, and the flag vector and a pending summary go to the interrupt logic. Each interrupt line is tracked by its own four-state machine that records both the last sampled level of the line and whether an event is pending. Reset puts every machine in `LN_QUIET_LO` and clears all flags, so the processor starts in supervisor mode with paging off.

The per-line states are:
- `LN_QUIET_LO`: no event pending, line last seen low.
- `LN_QUIET_HI`: no event pending, line last seen high.
- `LN_PEND_LO`: event pending, line last seen low.
- `LN_PEND_HI`: event pending, line last seen high.

The transitions are:
- **raise**: a high sample in a `*_LO` state moves to `LN_PEND_HI`. This happens even when a clear for that line arrives in the same cycle.
- **drop**: a low sample moves to the `*_LO` state of the same pending status, unless a clear applies.
- **acknowledge**: a clear while pending moves to `LN_QUIET_*` at the sampled level, unless a raise happens in that cycle.

Top module: `sfi_status_unit`

## Requirements
- R1: Reset, an active-low asynchronous `rst_n`, clears the readback word, the interrupt flags, `irq_pending_o`, `paging_en_o` and `user_mode_o`. After reset the mode is supervisor (0) and paging is off.
- R2: When `ld_flags_i` is high at a clock edge, paging enable takes Z bit 8 and mode takes Z bit 7 (1 = user). All other Z bits have no effect on the flags, and the status bits keep their value.
- R3: When `ld_status_i` is high at a clock edge, status bit 0 takes `alu_zero_i` and bit 1 takes `alu_carry_i`. Without the strobe, both bits hold, whatever the ALU outputs do.
- R4: In `word_o`, bit 8 is paging enable, bit 7 is mode, bit 1 is carry/overflow and bit 0 is zero. Every other bit reads 0.
- R5: A rising edge on `irq_req_i[i]` (high at an edge where it was low at the previous edge) sets flag i. The flag stays set whether the line stays high or falls, until it is cleared.
- R6: A line held high does not set its flag again after the flag is cleared. Only a new low-to-high transition does.
- R7: When `clr_irq_i` is high, each flag i whose Z bit i is 1 is cleared, and flags whose mask bit is 0 are unchanged. Without `clr_irq_i`, Z has no effect on the flags.
- R8: If a rising edge and a clear for the same line fall in the same cycle, the flag ends up set.
- R9: `irq_pending_o` is 1 exactly when at least one interrupt flag is set.
- R10: `ld_flags_i`, `ld_status_i` and `clr_irq_i` may fire in the same cycle, and each takes effect independently.
- R11: `paging_en_o` and `user_mode_o` always equal bits 8 and 7 of `word_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| z_bus_i | input | WORD_W (16) | Internal Z bus: flag source and clear mask |
| alu_zero_i | input | 1 | ALU result-is-zero output |
| alu_carry_i | input | 1 | ALU carry/overflow output |
| irq_req_i | input | IRQ_N (8) | Interrupt request lines |
| ld_flags_i | input | 1 | Strobe: load control flags from Z |
| ld_status_i | input | 1 | Strobe: capture ALU status |
| clr_irq_i | input | 1 | Strobe: clear interrupt flags by Z mask |
| word_o | output | WORD_W (16) | Flags/status readback word |
| paging_en_o | output | 1 | Paging enable flag |
| user_mode_o | output | 1 | Mode flag, 1 = user |
| irq_flags_o | output | IRQ_N (8) | Latched interrupt flags |
| irq_pending_o | output | 1 | OR of all interrupt flags |

## Verification
The bench loads the flags with a Z value whose other bits are all ones. A design that decodes the wrong bits, or lets stray bits into the word, shows a wrong word. It changes the ALU outputs with no strobe, which exposes status bits that follow the ALU instead of latching. It clears a flag while its line stays high and expects no re-trigger, which catches a design that latches levels. It also fires a raise and a clear on one line in the same cycle, where a design that gives priority to the clear loses the event. Clears whose mask selects unset or neighbouring lines, and Z activity without the clear strobe, check that only the selected flags drop.

// File: rtl/sfi_pkg.sv
package sfi_pkg;

    // Bit positions inside the readback word; the datapath decodes these.
    localparam int unsigned POS_ZERO  = 0;
    localparam int unsigned POS_CARRY = 1;
    localparam int unsigned POS_MODE  = 7;
    localparam int unsigned POS_PE    = 8;

    typedef enum logic {
        MODE_SUPER = 1'b0,
        MODE_USER  = 1'b1
    } cpu_mode_e;

    typedef enum logic {
        PAGING_OFF = 1'b0,
        PAGING_ON  = 1'b1
    } paging_e;

    // Per-line tracker: pending status x last sampled level
    typedef enum logic [1:0] {
        LN_QUIET_LO = 2'b00,
        LN_QUIET_HI = 2'b01,
        LN_PEND_LO  = 2'b10,
        LN_PEND_HI  = 2'b11
    } line_state_e;

    typedef struct packed {
        logic carry;
        logic zero;
    } alu_status_t;

endpackage

// File: rtl/sfi_irq_line.sv
module sfi_irq_line
    import sfi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic clr_i,
    output logic flag_o
);

    line_state_e state_q;
    line_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LN_QUIET_LO;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: raise beats acknowledge
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_QUIET_LO: begin
                state_d = req_i ? LN_PEND_HI : LN_QUIET_LO;
            end
            LN_QUIET_HI: begin
                state_d = req_i ? LN_QUIET_HI : LN_QUIET_LO;
            end
            LN_PEND_LO: begin
                if (req_i) begin
                    state_d = LN_PEND_HI;
                end else begin
                    state_d = clr_i ? LN_QUIET_LO : LN_PEND_LO;
                end
            end
            LN_PEND_HI: begin
                if (req_i) begin
                    state_d = clr_i ? LN_QUIET_HI : LN_PEND_HI;
                end else begin
                    state_d = clr_i ? LN_QUIET_LO : LN_PEND_LO;
                end
            end
            default: begin
                state_d = LN_QUIET_LO;
            end
        endcase
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            LN_PEND_LO, LN_PEND_HI: flag_o = 1'b1;
            default:                flag_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/sfi_ctrl_regs.sv
module sfi_ctrl_regs
    import sfi_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ld_flags_i,
    input  logic        pe_bit_i,
    input  logic        mode_bit_i,
    input  logic        ld_status_i,
    input  alu_status_t alu_i,
    output paging_e     paging_o,
    output cpu_mode_e   mode_o,
    output alu_status_t status_o
);

    paging_e     paging_q, paging_d;
    cpu_mode_e   mode_q,   mode_d;
    alu_status_t stat_q,   stat_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            paging_q <= PAGING_OFF;
            mode_q   <= MODE_SUPER;
            stat_q   <= '0;
        end else begin
            paging_q <= paging_d;
            mode_q   <= mode_d;
            stat_q   <= stat_d;
        end
    end

    always_comb begin
        paging_d = paging_q;
        mode_d   = mode_q;
        if (ld_flags_i) begin
            paging_d = pe_bit_i   ? PAGING_ON : PAGING_OFF;
            mode_d   = mode_bit_i ? MODE_USER : MODE_SUPER;
        end
    end

    always_comb begin
        stat_d = ld_status_i ? alu_i : stat_q;
    end

    assign paging_o = paging_q;
    assign mode_o   = mode_q;
    assign status_o = stat_q;

endmodule

// File: rtl/sfi_word_pack.sv
module sfi_word_pack
    import sfi_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  paging_e           paging_i,
    input  cpu_mode_e         mode_i,
    input  alu_status_t       status_i,
    output logic [WORD_W-1:0] word_o
);

    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        if (b == POS_PE) begin : g_pe
            assign word_o[b] = (paging_i == PAGING_ON);
        end else if (b == POS_MODE) begin : g_mode
            assign word_o[b] = (mode_i == MODE_USER);
        end else if (b == POS_CARRY) begin : g_carry
            assign word_o[b] = status_i.carry;
        end else if (b == POS_ZERO) begin : g_zero
            assign word_o[b] = status_i.zero;
        end else begin : g_rsvd
            assign word_o[b] = 1'b0;
        end
    end

endmodule

// File: rtl/sfi_status_unit.sv
module sfi_status_unit
    import sfi_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned IRQ_N  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] z_bus_i,
    input  logic              alu_zero_i,
    input  logic              alu_carry_i,
    input  logic [IRQ_N-1:0]  irq_req_i,
    input  logic              ld_flags_i,
    input  logic              ld_status_i,
    input  logic              clr_irq_i,
    output logic [WORD_W-1:0] word_o,
    output logic              paging_en_o,
    output logic              user_mode_o,
    output logic [IRQ_N-1:0]  irq_flags_o,
    output logic              irq_pending_o
);

    localparam int unsigned MASK_W = (IRQ_N < WORD_W) ? IRQ_N : WORD_W;

    paging_e     paging;
    cpu_mode_e   mode;
    alu_status_t status;
    alu_status_t alu_now;
    logic [IRQ_N-1:0] clr_mask;

    assign alu_now.zero  = alu_zero_i;
    assign alu_now.carry = alu_carry_i;

    sfi_ctrl_regs u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_flags_i  (ld_flags_i),
        .pe_bit_i    (z_bus_i[POS_PE]),
        .mode_bit_i  (z_bus_i[POS_MODE]),
        .ld_status_i (ld_status_i),
        .alu_i       (alu_now),
        .paging_o    (paging),
        .mode_o      (mode),
        .status_o    (status)
    );

    sfi_word_pack #(.WORD_W(WORD_W)) u_pack (
        .paging_i (paging),
        .mode_i   (mode),
        .status_i (status),
        .word_o   (word_o)
    );

    for (genvar i = 0; i < IRQ_N; i++) begin : g_line
        if (i < MASK_W) begin : g_mask
            assign clr_mask[i] = clr_irq_i & z_bus_i[i];
        end else begin : g_nomask
            assign clr_mask[i] = 1'b0;
        end

        sfi_irq_line u_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_i  (irq_req_i[i]),
            .clr_i  (clr_mask[i]),
            .flag_o (irq_flags_o[i])
        );
    end

    assign paging_en_o   = (paging == PAGING_ON);
    assign user_mode_o   = (mode == MODE_USER);
    assign irq_pending_o = |irq_flags_o;

endmodule

// File: rtl/sfi_status_unit_chk.sv
module sfi_status_unit_chk
    import sfi_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned IRQ_N  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] z_bus_i,
    input logic              alu_zero_i,
    input logic              alu_carry_i,
    input logic [IRQ_N-1:0]  irq_req_i,
    input logic              ld_flags_i,
    input logic              ld_status_i,
    input logic              clr_irq_i,
    input logic [WORD_W-1:0] word_o,
    input logic              paging_en_o,
    input logic              user_mode_o,
    input logic [IRQ_N-1:0]  irq_flags_o,
    input logic              irq_pending_o
);

    localparam logic [WORD_W-1:0] USED =
        (WORD_W'(1) << POS_PE) | (WORD_W'(1) << POS_MODE) |
        (WORD_W'(1) << POS_CARRY) | (WORD_W'(1) << POS_ZERO);

    assert_flags_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_flags_i |=> (word_o[POS_PE] == $past(z_bus_i[POS_PE])) &&
                       (word_o[POS_MODE] == $past(z_bus_i[POS_MODE])));

    assert_flags_keep_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_flags_i && !ld_status_i) |=> $stable(word_o[POS_CARRY:POS_ZERO]));

    assert_status_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_status_i |=> (word_o[POS_ZERO] == $past(alu_zero_i)) &&
                        (word_o[POS_CARRY] == $past(alu_carry_i)));

    assert_status_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_status_i |=> $stable(word_o[POS_CARRY:POS_ZERO]));

    assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_o & ~USED) == '0);

    assert_pins_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (paging_en_o == word_o[POS_PE]) && (user_mode_o == word_o[POS_MODE]));

    assert_pending_none_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_flags_o) == '0 && irq_req_i == '0 && $past(irq_req_i) == '0)
            |=> !irq_pending_o);

    for (genvar i = 0; i < IRQ_N; i++) begin : g_chk
        assert_rise_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_req_i[i] && !$past(irq_req_i[i])) |=> irq_flags_o[i]);

        assert_flag_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_flags_o[i] && !(clr_irq_i && z_bus_i[i])) |=> irq_flags_o[i]);

        assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_req_i[i] && !$past(irq_req_i[i]) && clr_irq_i && z_bus_i[i])
                |=> irq_flags_o[i]);

        assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_irq_i && z_bus_i[i] && !(irq_req_i[i] && !$past(irq_req_i[i])))
                |=> !irq_flags_o[i]);

        assert_level_no_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!irq_flags_o[i] && !(irq_req_i[i] && !$past(irq_req_i[i])))
                |=> !irq_flags_o[i]);
    end

endmodule

bind sfi_status_unit sfi_status_unit_chk #(.WORD_W(WORD_W), .IRQ_N(IRQ_N)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .z_bus_i       (z_bus_i),
    .alu_zero_i    (alu_zero_i),
    .alu_carry_i   (alu_carry_i),
    .irq_req_i     (irq_req_i),
    .ld_flags_i    (ld_flags_i),
    .ld_status_i   (ld_status_i),
    .clr_irq_i     (clr_irq_i),
    .word_o        (word_o),
    .paging_en_o   (paging_en_o),
    .user_mode_o   (user_mode_o),
    .irq_flags_o   (irq_flags_o),
    .irq_pending_o (irq_pending_o)
);

// File: tb/sfi_status_unit_test.sv
module sfi_status_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] z_bus = '0;
    logic        alu_zero = 1'b0;
    logic        alu_carry = 1'b0;
    logic [7:0]  irq_req = '0;
    logic        ld_flags = 1'b0;
    logic        ld_status = 1'b0;
    logic        clr_irq = 1'b0;
    logic [15:0] word;
    logic        paging_en;
    logic        user_mode;
    logic [7:0]  irq_flags;
    logic        irq_pending;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfi_status_unit uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .z_bus_i       (z_bus),
        .alu_zero_i    (alu_zero),
        .alu_carry_i   (alu_carry),
        .irq_req_i     (irq_req),
        .ld_flags_i    (ld_flags),
        .ld_status_i   (ld_status),
        .clr_irq_i     (clr_irq),
        .word_o        (word),
        .paging_en_o   (paging_en),
        .user_mode_o   (user_mode),
        .irq_flags_o   (irq_flags),
        .irq_pending_o (irq_pending)
    );

    typedef struct {
        logic [15:0] word;
        logic [7:0]  flags;
        logic        pend;
        string       tag;
    } exp_t;

    exp_t sb[$];

    // Reference model state, built from the requirements
    logic       m_pe, m_mode, m_zero, m_carry;
    logic [7:0] m_flags, m_prev;

    function automatic logic [15:0] model_word();
        logic [15:0] w = '0;
        w[8] = m_pe;
        w[7] = m_mode;
        w[1] = m_carry;
        w[0] = m_zero;
        return w;
    endfunction

    task automatic model_reset();
        m_pe = 0; m_mode = 0; m_zero = 0; m_carry = 0;
        m_flags = '0; m_prev = '0;
    endtask

    // Driver: one clock of stimulus, expected result pushed to the scoreboard
    task automatic step(input logic [15:0] z, input logic az, input logic ac,
                        input logic [7:0] req, input logic lf, input logic ls,
                        input logic lc, input string tag);
        exp_t e;
        logic [7:0] rise;
        @(negedge clk);
        z_bus = z; alu_zero = az; alu_carry = ac; irq_req = req;
        ld_flags = lf; ld_status = ls; clr_irq = lc;
        rise = req & ~m_prev;
        m_flags = rise | (m_flags & ~(lc ? z[7:0] : 8'h00));
        m_prev = req;
        if (lf) begin m_pe = z[8]; m_mode = z[7]; end
        if (ls) begin m_zero = az; m_carry = ac; end
        e.word = model_word();
        e.flags = m_flags;
        e.pend = |m_flags;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(16'h0000, alu_zero, alu_carry, irq_req, 0, 0, 0, tag);
    endtask

    // Monitor: compares a quarter period after each active edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (word !== e.word || irq_flags !== e.flags || irq_pending !== e.pend ||
                    paging_en !== e.word[8] || user_mode !== e.word[7]) begin
                    errors++;
                    $display("FAIL %s: word=%h flags=%b pend=%b pe=%b mode=%b expected word=%h flags=%b pend=%b",
                             e.tag, word, irq_flags, irq_pending, paging_en, user_mode,
                             e.word, e.flags, e.pend);
                end
            end
        end
    end

    task automatic check_zero(input string tag);
        checks++;
        if (word !== 16'h0000 || irq_flags !== 8'h00 || irq_pending !== 1'b0 ||
            paging_en !== 1'b0 || user_mode !== 1'b0) begin
            errors++;
            $display("FAIL %s: word=%h flags=%b pend=%b pe=%b mode=%b expected all zero",
                     tag, word, irq_flags, irq_pending, paging_en, user_mode);
        end
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        check_zero("R1 reset state");
        rst_n = 1'b1;
        idle("R1 idle after reset");

        // R2: only bits 8 and 7 of Z reach the flags
        step(16'hFE7F, 0, 0, 8'h00, 1, 0, 0, "R2 stray Z bits ignored");
        step(16'h0100, 0, 0, 8'h00, 1, 0, 0, "R2 paging on");
        step(16'h0080, 0, 0, 8'h00, 1, 0, 0, "R2 user mode, paging off");
        step(16'hFFFF, 1, 1, 8'h00, 0, 0, 0, "R2 no strobe holds flags");

        // R3: status latches only on its strobe
        step(16'h0000, 1, 0, 8'h00, 0, 1, 0, "R3 zero captured");
        step(16'h0000, 0, 1, 8'h00, 0, 0, 0, "R3 ALU change without strobe");
        step(16'h0000, 0, 1, 8'h00, 0, 1, 0, "R3 carry captured");
        step(16'h0180, 1, 1, 8'h00, 1, 0, 0, "R2 flags load keeps status");

        // R10: all three strobes together
        step(16'h00FF, 1, 0, 8'h00, 1, 1, 1, "R10 simultaneous strobes");

        // R5: rising edge sets, flag survives hold and drop
        step(16'h0000, 0, 0, 8'h04, 0, 0, 0, "R5 line 2 rises");
        step(16'h0000, 0, 0, 8'h04, 0, 0, 0, "R5 line 2 held");
        step(16'h0000, 0, 0, 8'h00, 0, 0, 0, "R5 line 2 dropped, flag kept");
        step(16'h00FF, 0, 0, 8'h00, 0, 0, 0, "R7 Z without clear strobe");

        // R7: selective write-one-to-clear
        step(16'h0000, 0, 0, 8'h81, 0, 0, 0, "R9 lines 0 and 7 rise");
        step(16'h0024, 0, 0, 8'h81, 0, 0, 1, "R7 clear 2 and unset 5");
        step(16'h0000, 0, 0, 8'h81, 0, 0, 1, "R7 empty mask clears none");
        step(16'h0001, 0, 0, 8'h81, 0, 0, 1, "R7 clear 0 only");

        // R6: held-high line does not re-trigger after clear
        step(16'h0000, 0, 0, 8'h81, 0, 0, 0, "R6 line 0 still high");
        step(16'h0000, 0, 0, 8'h80, 0, 0, 0, "R6 line 0 falls");
        step(16'h0000, 0, 0, 8'h81, 0, 0, 0, "R5 line 0 rises again");

        // R8: set beats clear in same cycle
        step(16'h0008, 0, 0, 8'h89, 0, 0, 1, "R8 raise and clear line 3");
        step(16'h00FF, 0, 0, 8'h89, 0, 0, 1, "R9 clear all, lines held");
        step(16'h0000, 0, 0, 8'h89, 0, 0, 0, "R9 nothing pending");
        step(16'h0000, 0, 0, 8'h00, 0, 0, 0, "R9 all lines low");
        step(16'h0000, 0, 0, 8'h40, 0, 0, 0, "R9 line 6 pending");

        // R1: reset mid-run wipes everything
        @(negedge clk);
        while (sb.size() > 0) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_zero("R1 reset mid-run");
        model_reset();
        irq_req = 8'h00;
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1 after second reset");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule